// File: doc/BRIEF.md
# Interpolating I/Q Quadrature Modulation Datapath

This block is the digital path between a parallel two-channel sample bus (real and imaginary, 14 bits each) and a pair of DAC cores. It runs on a single clock at the DAC update rate. Input samples arrive with a valid strobe once every 1, 2, 4 or 8 clocks. The entry register takes either two's complement or offset binary data. The samples then pass through three cascaded ×2 interpolation stages, and each stage is enabled or bypassed according to the selected overall factor. The output words go to the DAC cores in offset binary, together with a per-sample strobe.

A quadrature modulator sits after the second interpolation stage and before the third. It therefore sees twice the input rate in ×2 mode and four times the input rate in ×4 and ×8 modes. The modulator can shift the complex signal by half or by a quarter of its own input rate, or pass it through unchanged. Each channel's output can be parked at midscale on its own. When both channels are parked, the whole datapath freezes in place and new input samples are ignored.

Top module: `iq_interp_mod`

## Requirements
- R1: `interp_sel_i` = 0, 1, 2, 3 selects an overall factor L = 1, 2, 4, 8. For N input samples presented one every L clocks, exactly N·L output strobes result, and after the first one they come on consecutive clocks with no gap.
- R2: Each active ×2 stage turns an input stream x[k] into y[2k] = x[k−1] and y[2k+1] = (x[k−1] + x[k] + 1) >> 1, using an arithmetic shift and taking x[−1] = 0 after reset. Stages with index ≥ `interp_sel_i` pass samples through unchanged.
- R3: When `offset_bin_i` = 1, the input words are offset binary and the block inverts their MSB to get two's complement. When it is 0, the words are two's complement. The outputs are always offset binary, which is the two's complement value with its MSB inverted.
- R4: The modulator acts on the stream after stages 0 and 1, and stage 2 follows it. With `interp_sel_i` = 0 the modulator is bypassed whatever `mod_sel_i` holds.
- R5: `mod_sel_i` = 1 gives the half-rate shift. Modulator samples with an odd index, counted from 0 since reset, have both channels negated. Even-indexed samples pass unchanged.
- R6: `mod_sel_i` = 2 gives the quarter-rate shift. For modulator sample index n mod 4 = 0, 1, 2, 3 the output (re, im) is (I, Q), (−Q, I), (−I, −Q) and (Q, −I) respectively.
- R7: Negation in the modulator saturates, so −8192 maps to +8191.
- R8: `mod_sel_i` = 0 or 3 turns modulation off. The real and imaginary inputs then reach their own outputs, changed only by interpolation.
- R9: While `off_re_i` (or `off_im_i`) is high, that channel's output is 14'h2000 from the next clock on. The other channel keeps running.
- R10: While both `off_re_i` and `off_im_i` are high, `dac_valid_o` is 0, both outputs are 14'h2000, `valid_i` is ignored and all stage state is held. After release, the output stream continues as if the ignored samples had never been presented.
- R11: During and right after reset, `dac_valid_o` is 0 and both outputs read 14'h2000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | DAC-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| interp_sel_i | input | 2 | Interpolation factor select (0..3 → 1×..8×) |
| mod_sel_i | input | 2 | Modulation select: 0/3 off, 1 half rate, 2 quarter rate |
| offset_bin_i | input | 1 | Input word format: 1 offset binary, 0 two's complement |
| off_re_i | input | 1 | Park real channel at midscale |
| off_im_i | input | 1 | Park imaginary channel at midscale |
| valid_i | input | 1 | Input sample strobe |
| data_re_i | input | 14 | Real input sample |
| data_im_i | input | 14 | Imaginary input sample |
| dac_valid_o | output | 1 | Output sample strobe |
| dac_re_o | output | 14 | Real output to DAC core, offset binary |
| dac_im_o | output | 14 | Imaginary output to DAC core, offset binary |

## Verification
The first output strobe comes six clocks after the first accepted input. Those clocks are the entry register, three stage registers, the modulator register and the output register. Every active stage also holds back one input period's worth of its stream. For this reason the bench records outputs in strobe order and compares them by index against a stream model once the pipeline has drained, with the count and the gap-free run of strobes checked separately. The effects of the park inputs are due one clock after they change, so the bench samples those a clock later, away from the edge. The modulator assertions relate its input in one cycle to its output in the next.

// File: rtl/iqm_pkg.sv
package iqm_pkg;
  localparam int NUM_CH = 2;  // index 0 = real, 1 = imaginary

  typedef enum logic [1:0] {
    MOD_OFF     = 2'd0,
    MOD_HALF    = 2'd1,
    MOD_QUARTER = 2'd2,
    MOD_OFF_ALT = 2'd3
  } mod_mode_e;
endpackage

// File: rtl/iqm_in_fmt.sv
module iqm_in_fmt
  import iqm_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           hold_i,
  input  logic                           offset_bin_i,
  input  logic                           valid_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  data_i,
  output logic                           valid_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]  data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (!hold_i) begin
      valid_o <= valid_i;
      if (valid_i) begin
        for (int c = 0; c < NUM_CH; c++)
          data_o[c] <= {data_i[c][DATA_W-1] ^ offset_bin_i, data_i[c][DATA_W-2:0]};
      end
    end
  end
endmodule

// File: rtl/iqm_hb_stage.sv
// x2 stage: zero-stuff + [1 2 1]/2 half-band, i.e. hold then rounded midpoint.
module iqm_hb_stage
  import iqm_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int CNT_W  = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           hold_i,
  input  logic                           active_i,
  input  logic [CNT_W-1:0]               half_i,
  input  logic                           in_v_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  in_d_i,
  output logic                           out_v_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]  out_d_o
);
  logic [NUM_CH-1:0][DATA_W-1:0] prev_q, mid_q, mid_n;
  logic [NUM_CH-1:0][DATA_W:0]   sum_w;
  logic [CNT_W-1:0]              cnt_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign sum_w[c] = $signed({prev_q[c][DATA_W-1], prev_q[c]})
                    + $signed({in_d_i[c][DATA_W-1], in_d_i[c]})
                    + $signed((DATA_W+1)'(1));
    assign mid_n[c] = DATA_W'($signed(sum_w[c]) >>> 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      mid_q   <= '0;
      cnt_q   <= '0;
      out_v_o <= 1'b0;
      out_d_o <= '0;
    end else if (!hold_i) begin
      out_v_o <= 1'b0;
      if (!active_i) begin
        out_v_o <= in_v_i;
        out_d_o <= in_d_i;
        cnt_q   <= '0;
      end else if (in_v_i) begin
        out_v_o <= 1'b1;
        out_d_o <= prev_q;
        mid_q   <= mid_n;
        prev_q  <= in_d_i;
        cnt_q   <= half_i;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          out_v_o <= 1'b1;
          out_d_o <= mid_q;
        end
      end
    end
  end
endmodule

// File: rtl/iqm_quad_mod.sv
module iqm_quad_mod
  import iqm_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           hold_i,
  input  mod_mode_e                      mode_i,
  input  logic                           in_v_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  in_d_i,
  output logic                           out_v_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]  out_d_o
);
  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic logic [DATA_W-1:0] sneg(input logic [DATA_W-1:0] v);
    return (v == MIN_V) ? ~MIN_V : (~v + 1'b1);
  endfunction

  logic [1:0]                    ph_q;
  logic [NUM_CH-1:0][DATA_W-1:0] rot_w;
  logic [DATA_W-1:0]             re_w, im_w;

  assign re_w = in_d_i[0];
  assign im_w = in_d_i[1];

  always_comb begin
    rot_w = in_d_i;
    unique case (mode_i)
      MOD_HALF: if (ph_q[0]) rot_w = {sneg(im_w), sneg(re_w)};
      MOD_QUARTER: begin
        unique case (ph_q)
          2'd0: rot_w = {im_w, re_w};
          2'd1: rot_w = {re_w, sneg(im_w)};
          2'd2: rot_w = {sneg(im_w), sneg(re_w)};
          2'd3: rot_w = {sneg(re_w), im_w};
        endcase
      end
      default: rot_w = in_d_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= '0;
      out_v_o <= 1'b0;
      out_d_o <= '0;
    end else if (!hold_i) begin
      out_v_o <= in_v_i;
      if (in_v_i) begin
        ph_q    <= ph_q + 1'b1;
        out_d_o <= rot_w;
      end
    end
  end
endmodule

// File: rtl/iq_interp_mod.sv
module iq_interp_mod
  import iqm_pkg::*;
#(
  parameter int DATA_W    = 14,
  parameter int NUM_STG   = 3,
  parameter int MOD_AFTER = 2,
  localparam int SEL_W    = $clog2(NUM_STG + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  interp_sel_i,
  input  logic [1:0]        mod_sel_i,
  input  logic              offset_bin_i,
  input  logic              off_re_i,
  input  logic              off_im_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_re_i,
  input  logic [DATA_W-1:0] data_im_i,
  output logic              dac_valid_o,
  output logic [DATA_W-1:0] dac_re_o,
  output logic [DATA_W-1:0] dac_im_o
);
  localparam int CNT_W  = NUM_STG;
  localparam int RATE_W = NUM_STG + 1;
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  typedef logic [NUM_CH-1:0][DATA_W-1:0] pair_t;

  logic             sleep;
  logic [SEL_W-1:0] n_act;
  logic [RATE_W-1:0] rate_w;
  mod_mode_e        mod_eff;

  logic  fmt_v;
  pair_t fmt_d;
  logic  st_v [NUM_STG];
  pair_t st_d [NUM_STG];
  logic  mod_in_v, mod_out_v;
  pair_t mod_in_d, mod_out_d;

  assign sleep   = off_re_i & off_im_i;
  assign n_act   = (interp_sel_i > SEL_W'(NUM_STG)) ? SEL_W'(NUM_STG) : interp_sel_i;
  assign rate_w  = RATE_W'(1) << n_act;
  assign mod_eff = (n_act == '0) ? MOD_OFF : mod_mode_e'(mod_sel_i);

  iqm_in_fmt #(.DATA_W(DATA_W)) u_fmt (
    .clk_i, .rst_ni,
    .hold_i       (sleep),
    .offset_bin_i,
    .valid_i,
    .data_i       ({data_im_i, data_re_i}),
    .valid_o      (fmt_v),
    .data_o       (fmt_d)
  );

  assign mod_in_v = st_v[MOD_AFTER-1];
  assign mod_in_d = st_d[MOD_AFTER-1];

  iqm_quad_mod #(.DATA_W(DATA_W)) u_mod (
    .clk_i, .rst_ni,
    .hold_i  (sleep),
    .mode_i  (mod_eff),
    .in_v_i  (mod_in_v),
    .in_d_i  (mod_in_d),
    .out_v_o (mod_out_v),
    .out_d_o (mod_out_d)
  );

  for (genvar j = 0; j < NUM_STG; j++) begin : g_stg
    logic             in_v;
    pair_t            in_d;
    logic [CNT_W-1:0] half;

    if (j == 0) begin : g_src_fmt
      assign in_v = fmt_v;
      assign in_d = fmt_d;
    end else if (j == MOD_AFTER) begin : g_src_mod
      assign in_v = mod_out_v;
      assign in_d = mod_out_d;
    end else begin : g_src_prev
      assign in_v = st_v[j-1];
      assign in_d = st_d[j-1];
    end

    assign half = CNT_W'(rate_w >> (j + 1));

    iqm_hb_stage #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_stg (
      .clk_i, .rst_ni,
      .hold_i   (sleep),
      .active_i (n_act > SEL_W'(j)),
      .half_i   (half),
      .in_v_i   (in_v),
      .in_d_i   (in_d),
      .out_v_o  (st_v[j]),
      .out_d_o  (st_d[j])
    );
  end

  // Output: two's complement -> offset binary, parked channels at midscale.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_valid_o <= 1'b0;
      dac_re_o    <= MID;
      dac_im_o    <= MID;
    end else begin
      dac_valid_o <= st_v[NUM_STG-1] & ~sleep;
      if (off_re_i) dac_re_o <= MID;
      else if (st_v[NUM_STG-1]) dac_re_o <= st_d[NUM_STG-1][0] ^ MID;
      if (off_im_i) dac_im_o <= MID;
      else if (st_v[NUM_STG-1]) dac_im_o <= st_d[NUM_STG-1][1] ^ MID;
    end
  end
endmodule

// File: rtl/iq_interp_mod_chk.sv
module iq_interp_mod_chk #(
  parameter int DATA_W = 14
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    sleep,
  input logic [1:0]              mod_mode,
  input logic                    mod_in_v,
  input logic [1:0][DATA_W-1:0]  mod_in_d,
  input logic                    mod_out_v,
  input logic [1:0][DATA_W-1:0]  mod_out_d,
  input logic                    off_re_i,
  input logic                    off_im_i,
  input logic                    dac_valid_o,
  input logic [DATA_W-1:0]       dac_re_o,
  input logic [DATA_W-1:0]       dac_im_o
);
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic logic [DATA_W-1:0] ng(input logic [DATA_W-1:0] v);
    return (v == MID) ? ~MID : (~v + 1'b1);
  endfunction

  logic [1:0] ph;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph <= '0;
    else if (mod_in_v && !sleep) ph <= ph + 1'b1;
  end

  p_sleep_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep |=> !dac_valid_o && dac_re_o == MID && dac_im_o == MID);

  p_re_park_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_re_i |=> dac_re_o == MID);

  p_im_park_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_im_i |=> dac_im_o == MID);

  p_off_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_in_v && !sleep && (mod_mode == 2'd0 || mod_mode == 2'd3))
    |=> mod_out_v && mod_out_d == $past(mod_in_d));

  p_half_even_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_in_v && !sleep && mod_mode == 2'd1 && !ph[0])
    |=> mod_out_v && mod_out_d == $past(mod_in_d));

  p_half_odd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_in_v && !sleep && mod_mode == 2'd1 && ph[0])
    |=> mod_out_d[0] == ng($past(mod_in_d[0])) && mod_out_d[1] == ng($past(mod_in_d[1])));

  p_quarter_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_in_v && !sleep && mod_mode == 2'd2 && ph == 2'd1)
    |=> mod_out_d[0] == ng($past(mod_in_d[1])) && mod_out_d[1] == $past(mod_in_d[0]));

  p_quarter_three_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_in_v && !sleep && mod_mode == 2'd2 && ph == 2'd3)
    |=> mod_out_d[0] == $past(mod_in_d[1]) && mod_out_d[1] == ng($past(mod_in_d[0])));
endmodule

bind iq_interp_mod iq_interp_mod_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sleep       (sleep),
  .mod_mode    (mod_eff),
  .mod_in_v    (mod_in_v),
  .mod_in_d    (mod_in_d),
  .mod_out_v   (mod_out_v),
  .mod_out_d   (mod_out_d),
  .off_re_i    (off_re_i),
  .off_im_i    (off_im_i),
  .dac_valid_o (dac_valid_o),
  .dac_re_o    (dac_re_o),
  .dac_im_o    (dac_im_o)
);

// File: tb/iq_interp_mod_bench.sv
`timescale 1ns/1ps
module iq_interp_mod_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  interp_sel_i = '0;
  logic [1:0]  mod_sel_i = '0;
  logic        offset_bin_i = 1'b0;
  logic        off_re_i = 1'b0;
  logic        off_im_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [13:0] data_re_i = '0;
  logic [13:0] data_im_i = '0;
  logic        dac_valid_o;
  logic [13:0] dac_re_o, dac_im_o;

  always #2 clk_i = ~clk_i;

  iq_interp_mod u_iq_interp_mod (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  int in_re[64], in_im[64];
  int w_re[1024], w_im[1024], t_re[1024], t_im[1024];
  int wl;
  int cap_re[1024], cap_im[1024];
  int n_cap = 0, cyc = 0, first_cyc = 0, last_cyc = 0;

  always @(negedge clk_i) begin
    cyc++;
    if (dac_valid_o && n_cap < 1024) begin
      if (n_cap == 0) first_cyc = cyc;
      last_cyc = cyc;
      cap_re[n_cap] = int'(dac_re_o);
      cap_im[n_cap] = int'(dac_im_o);
      n_cap++;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sneg(int v);
    return (v == -8192) ? 8191 : -v;
  endfunction

  function automatic int rnd_val();
    return int'($urandom_range(16383)) - 8192;
  endfunction

  // stream model: stage = hold previous + rounded midpoint (R2)
  task automatic model_interp();
    for (int k = 0; k < wl; k++) begin
      int pr, pi;
      pr = (k == 0) ? 0 : w_re[k-1];
      pi = (k == 0) ? 0 : w_im[k-1];
      t_re[2*k] = pr;  t_re[2*k+1] = (pr + w_re[k] + 1) >>> 1;
      t_im[2*k] = pi;  t_im[2*k+1] = (pi + w_im[k] + 1) >>> 1;
    end
    wl = wl * 2;
    for (int k = 0; k < wl; k++) begin w_re[k] = t_re[k]; w_im[k] = t_im[k]; end
  endtask

  task automatic model_mod(int mode);
    for (int n = 0; n < wl; n++) begin
      int a, b;
      a = w_re[n]; b = w_im[n];
      if (mode == 1 && (n % 2) == 1) begin w_re[n] = sneg(a); w_im[n] = sneg(b); end
      if (mode == 2) begin
        case (n % 4)
          1: begin w_re[n] = sneg(b); w_im[n] = a; end
          2: begin w_re[n] = sneg(a); w_im[n] = sneg(b); end
          3: begin w_re[n] = b; w_im[n] = sneg(a); end
          default: ;
        endcase
      end
    end
  endtask

  task automatic build_model(int sel, int mode, int n);
    wl = n;
    for (int k = 0; k < n; k++) begin w_re[k] = in_re[k]; w_im[k] = in_im[k]; end
    for (int j = 0; j < 3; j++) begin
      if (j == 2 && sel > 0) model_mod(mode);  // R4: modulator ahead of third stage
      if (j < sel) model_interp();
    end
  endtask

  task automatic do_reset(int sel, int mode, bit fmt, bit ore, bit oim);
    @(negedge clk_i);
    rst_ni = 1'b0; valid_i = 1'b0;
    interp_sel_i = 2'(sel); mod_sel_i = 2'(mode); offset_bin_i = fmt;
    off_re_i = ore; off_im_i = oim;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1;
    n_cap = 0;
  endtask

  task automatic drive(int a, int b, int l, bit fmt);
    for (int k = a; k < b; k++) begin
      @(negedge clk_i);
      valid_i = 1'b1;
      data_re_i = 14'(in_re[k]) ^ (fmt ? 14'h2000 : 14'h0000);
      data_im_i = 14'(in_im[k]) ^ (fmt ? 14'h2000 : 14'h0000);
      for (int r = 1; r < l; r++) @(negedge clk_i) valid_i = 1'b0;
    end
    @(negedge clk_i) valid_i = 1'b0;
  endtask

  task automatic compare(int n_exp, bit gap_chk, bit ore, bit oim, string dtag);
    int bad_re, bad_im, a_re, e_re, a_im, e_im;
    check(n_cap == n_exp, "R1 output count", n_cap, n_exp);
    if (gap_chk) check(last_cyc - first_cyc + 1 == n_cap, "R1 gap-free strobes",
                       last_cyc - first_cyc + 1, n_cap);
    bad_re = -1; bad_im = -1;
    for (int k = 0; k < n_exp && k < n_cap; k++) begin
      int er, ei;
      er = ore ? 8192 : ((w_re[k] + 8192) & 16'h3FFF);
      ei = oim ? 8192 : ((w_im[k] + 8192) & 16'h3FFF);
      if (bad_re < 0 && cap_re[k] != er) begin bad_re = k; a_re = cap_re[k]; e_re = er; end
      if (bad_im < 0 && cap_im[k] != ei) begin bad_im = k; a_im = cap_im[k]; e_im = ei; end
    end
    check(bad_re < 0, {dtag, ore ? " R9" : "", " real stream"}, a_re, e_re);
    check(bad_im < 0, {dtag, oim ? " R9" : "", " imag stream"}, a_im, e_im);
  endtask

  // pat: 0 const random, 1 DC step, 2 random, 3 const cval
  task automatic run_case(int sel, int mode, bit fmt, int pat, int n, int cval,
                          bit ore, bit oim, string xtag);
    int l, c0r, c0i, c1r, c1i;
    string mtag;
    l = 1 << sel;
    c0r = rnd_val(); c0i = rnd_val(); c1r = rnd_val(); c1i = rnd_val();
    for (int k = 0; k < n; k++) begin
      case (pat)
        0: begin in_re[k] = c0r; in_im[k] = c0i; end
        1: begin in_re[k] = (k < n/2) ? c0r : c1r; in_im[k] = (k < n/2) ? c0i : c1i; end
        2: begin in_re[k] = rnd_val(); in_im[k] = rnd_val(); end
        default: begin in_re[k] = cval; in_im[k] = cval; end
      endcase
    end
    do_reset(sel, mode, fmt, ore, oim);
    drive(0, n, l, fmt);
    repeat (40) @(posedge clk_i);
    #1;
    build_model(sel, mode, n);
    mtag = (sel == 0 || mode == 0 || mode == 3) ? "R8" : (mode == 1) ? "R5" : "R6";
    compare(n * l, 1'b1, ore, oim, {"R2/R3/R4/", mtag, xtag});
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset(0, 0, 0, 0, 0);
    check(dac_valid_o == 1'b0, "R11 reset strobe", int'(dac_valid_o), 0);
    check(dac_re_o == 14'h2000, "R11 reset real", int'(dac_re_o), 8192);
    check(dac_im_o == 14'h2000, "R11 reset imag", int'(dac_im_o), 8192);

    for (int sel = 0; sel < 4; sel++)
      for (int mode = 0; mode < 4; mode++)
        for (int pat = 0; pat < 3; pat++)
          run_case(sel, mode, 1'((sel + pat) % 2), pat, (pat == 2) ? 24 : 12, 0, 0, 0, "");

    run_case(1, 1, 0, 3, 12, -8192, 0, 0, " R7");
    run_case(2, 2, 1, 3, 12, -8192, 0, 0, " R7");
    run_case(3, 1, 0, 3, 12,  8191, 0, 0, " R7");
    run_case(2, 2, 0, 2, 16, 0, 1, 0, "");
    run_case(3, 1, 1, 2, 16, 0, 0, 1, "");

    // R10: both parked freezes the path and drops inputs
    begin
      int hold_cnt;
      for (int k = 0; k < 12; k++) begin in_re[k] = rnd_val(); in_im[k] = rnd_val(); end
      do_reset(2, 2, 0, 0, 0);
      drive(0, 4, 4, 0);
      repeat (20) @(posedge clk_i);
      @(negedge clk_i) begin off_re_i = 1'b1; off_im_i = 1'b1; end
      @(posedge clk_i); #1;
      hold_cnt = n_cap;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk_i);
        valid_i = 1'b1; data_re_i = 14'($urandom); data_im_i = 14'($urandom);
        repeat (3) @(negedge clk_i) valid_i = 1'b0;
      end
      repeat (10) @(posedge clk_i);
      #1;
      check(n_cap == hold_cnt, "R10 no strobes while parked", n_cap, hold_cnt);
      check(dac_re_o == 14'h2000 && dac_im_o == 14'h2000, "R10 midscale while parked",
            int'(dac_re_o), 8192);
      @(negedge clk_i) begin off_re_i = 1'b0; off_im_i = 1'b0; end
      drive(4, 12, 4, 0);
      repeat (40) @(posedge clk_i);
      #1;
      build_model(2, 2, 12);
      compare(48, 1'b0, 0, 0, "R10 resumed");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 200000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule